// File: doc/BRIEF.md
# High-Side Switch Timing Supervisor

This block holds the PWM latch of an asynchronous step-down converter and guards every timing limit on the high-side power switch. A period tick starts a conduction interval. The end of that interval comes from the PWM comparator, the overcurrent comparator or the light-load skip-current comparator. The supervisor stretches a request that arrives too early up to a minimum on-time. It cuts a conduction interval that runs too long. It also keeps the switch off for a minimum time before it may turn on again.

Duty may approach 100 % in low-dropout operation. The on-time is capped, though, and each cap event is followed by a short, timed pull-down of the switch node through a low-side device, so the bootstrap capacitor can recharge. This pull-down ends early when the negative current limit comparator fires. A separate idle timer issues the same pull-down when the high side has been off for a long time, which covers very light load. The pull-down and the high-side command are never active together, and at least one cycle with both low lies between them. All durations are parameters counted in clock cycles. All inputs are synchronous, single-bit comparator flags.

Top module: `hs_switch_guard`

## Requirements
- R1: Every high-side pulse lasts at least MIN_ON cycles. A turn-off request (pwm_end, ocp_trip or skip_cur_hit) seen before the MIN_ON-th high cycle is remembered, and the pulse then ends after exactly MIN_ON cycles.
- R2: A turn-off request sampled during the k-th high cycle, with MIN_ON <= k < MAX_ON, makes the pulse exactly k cycles long. All three request sources act the same way.
- R3: hs_on rises in the cycle after an edge that samples period_tick=1 and light_load=0, provided the switch has been low for at least MIN_OFF cycles. A tick sampled while hs_on is high has no effect.
- R4: Between two high-side pulses, hs_on stays low for at least MIN_OFF cycles. If period_tick is held high from the falling edge onward, the low interval is exactly MIN_OFF cycles.
- R5: Without a request before the MAX_ON-th cycle, hs_on falls after exactly MAX_ON cycles. A request in that same cycle does not change this. One cycle with both outputs low follows, and then ls_pull rises.
- R6: A pull-down lasts PULL_TMO cycles. If neg_ilim is sampled high during its j-th cycle, with j <= PULL_TMO, the pull-down lasts exactly j cycles.
- R7: While light_load is sampled high, period_tick cannot turn the high side on.
- R8: hs_on and ls_pull are never high in the same cycle. Every transition between them passes through at least one cycle with both low.
- R9: After IDLE_LIM consecutive low cycles of hs_on, counted from its falling edge, an idle pull-down starts. It ends by the R6 rules. While the high side stays off, idle pull-downs repeat with IDLE_LIM cycles from one rising edge of ls_pull to the next.
- R10: During and right after reset, hs_on and ls_pull are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_tick | input | 1 | One-cycle start-of-period pulse from the oscillator |
| pwm_end | input | 1 | Ramp has crossed the error level; end conduction |
| ocp_trip | input | 1 | Peak current limit reached; end conduction |
| light_load | input | 1 | Error level is below the skip threshold; block turn-on |
| skip_cur_hit | input | 1 | Inductor current reached the skip level; end conduction |
| neg_ilim | input | 1 | Negative current limit reached during a pull-down |
| hs_on | output | 1 | High-side gate command |
| ls_pull | output | 1 | Low-side switch-node pull-down command |

## Verification
Some properties hold on every cycle, and the assertions track these with their own run-length counters: the minimum and maximum pulse widths, the minimum off interval, the pull-down length cap, the exit on the negative limit, the light-load block and the dead cycle between the two commands. Other behaviours are exact cycle counts that only a stimulus sequence can reveal. These are the stretching of an early request to exactly MIN_ON, a pulse of exactly k cycles for a late request, the exact MIN_OFF gap under a held tick, the single dead cycle after an on-time cap, and the idle refresh spacing. The bench drives directed and seeded random pulses and measures each of these lengths at the ports.

// File: rtl/hsg_pkg.sv
package hsg_pkg;

    // Phases of the switch supervisor
    typedef enum logic [2:0] {
        PH_OFF     = 3'd0,   // high side off, off-time counting
        PH_ON      = 3'd1,   // high side conducting
        PH_GAP_IN  = 3'd2,   // dead cycle before a pull-down
        PH_PULL    = 3'd3,   // low-side pull-down active
        PH_GAP_OUT = 3'd4    // dead cycle after a pull-down
    } phase_e;

endpackage

// File: rtl/hsg_off_request.sv
// Merges the three turn-off sources and remembers one that arrives inside
// the minimum on-time so it acts once the blanking window has passed.
module hsg_off_request (
    input  logic clk,
    input  logic rst_n,
    input  logic on_active,
    input  logic blank_done,
    input  logic pwm_end,
    input  logic ocp_trip,
    input  logic skip_cur_hit,
    output logic stop_now
);

    typedef struct packed {
        logic pend;
    } req_t;

    req_t req_d, req_q;
    logic req_any;

    always_comb begin
        req_any  = pwm_end | ocp_trip | skip_cur_hit;
        stop_now = blank_done & (req_any | req_q.pend);
        req_d    = req_q;
        req_d.pend = on_active & ~stop_now & (req_q.pend | req_any);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    // R1: a request held pending is never dropped while the pulse continues
    a_r1_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (on_active && req_any && !blank_done) |=> (req_q.pend || !on_active));

endmodule

// File: rtl/hsg_idle_timer.sv
// Counts high-side idle cycles; restarts on conduction or on an idle pull-down.
module hsg_idle_timer #(
    parameter int IDLE_LIM = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_on,
    input  logic idle_fire,
    output logic idle_expired
);

    localparam int IW = $clog2(IDLE_LIM + 1) + 1;
    localparam logic [IW-1:0] C_LIM = IW'(IDLE_LIM);

    typedef struct packed {
        logic [IW-1:0] cnt;
    } idle_t;

    idle_t idle_d, idle_q;

    always_comb begin
        idle_d = idle_q;
        if (hs_on || idle_fire)     idle_d.cnt = IW'(1);
        else if (idle_q.cnt < C_LIM) idle_d.cnt = idle_q.cnt + IW'(1);
        idle_expired = (idle_q.cnt >= C_LIM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idle_q <= '0;
        else        idle_q <= idle_d;
    end

    // R9: the idle count never passes its limit
    a_r9_idle_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q.cnt <= C_LIM);

endmodule

// File: rtl/hsg_phase_fsm.sv
// Phase sequencer with one shared cycle counter for on, off and pull-down.
module hsg_phase_fsm
    import hsg_pkg::*;
#(
    parameter int MIN_ON   = 8,
    parameter int MIN_OFF  = 18,
    parameter int MAX_ON   = 600,
    parameter int PULL_TMO = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_tick,
    input  logic light_load,
    input  logic neg_ilim,
    input  logic stop_now,
    input  logic idle_expired,
    output logic hs_on,
    output logic ls_pull,
    output logic blank_done,
    output logic idle_fire
);

    localparam int TOP_A = (MAX_ON > MIN_OFF) ? MAX_ON : MIN_OFF;
    localparam int TOP   = (TOP_A > PULL_TMO) ? TOP_A : PULL_TMO;
    localparam int CW    = $clog2(TOP + 1) + 1;

    localparam logic [CW-1:0] C_MIN_ON  = CW'(MIN_ON);
    localparam logic [CW-1:0] C_MIN_OFF = CW'(MIN_OFF);
    localparam logic [CW-1:0] C_MAX_ON  = CW'(MAX_ON);
    localparam logic [CW-1:0] C_TMO     = CW'(PULL_TMO);
    localparam logic [CW-1:0] C_ONE     = CW'(1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d     = fsm_q;
        idle_fire = 1'b0;
        unique case (fsm_q.phase)
            PH_OFF: begin
                if (fsm_q.cnt >= C_MIN_OFF && period_tick && !light_load) begin
                    fsm_d.phase = PH_ON;
                    fsm_d.cnt   = C_ONE;
                end else if (idle_expired) begin
                    fsm_d.phase = PH_PULL;
                    fsm_d.cnt   = C_ONE;
                    idle_fire   = 1'b1;
                end else if (fsm_q.cnt < C_MIN_OFF) begin
                    fsm_d.cnt = fsm_q.cnt + C_ONE;
                end
            end
            PH_ON: begin
                if (fsm_q.cnt >= C_MAX_ON) begin
                    fsm_d.phase = PH_GAP_IN;
                    fsm_d.cnt   = '0;
                end else if (stop_now) begin
                    fsm_d.phase = PH_OFF;
                    fsm_d.cnt   = C_ONE;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + C_ONE;
                end
            end
            PH_GAP_IN: begin
                fsm_d.phase = PH_PULL;
                fsm_d.cnt   = C_ONE;
            end
            PH_PULL: begin
                if (neg_ilim || fsm_q.cnt >= C_TMO) begin
                    fsm_d.phase = PH_GAP_OUT;
                    fsm_d.cnt   = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + C_ONE;
                end
            end
            PH_GAP_OUT: begin
                fsm_d.phase = PH_OFF;
                fsm_d.cnt   = C_ONE;
            end
            default: begin
                fsm_d.phase = PH_OFF;
                fsm_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.phase <= PH_OFF;
            fsm_q.cnt   <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    always_comb begin
        hs_on      = (fsm_q.phase == PH_ON);
        ls_pull    = (fsm_q.phase == PH_PULL);
        blank_done = hs_on && (fsm_q.cnt >= C_MIN_ON);
    end

    // R3: a pull-down never hands over straight to conduction
    a_r3_on_from_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> ($past(fsm_q.phase) == PH_OFF));

endmodule

// File: rtl/hs_switch_guard.sv
// Top: high-side PWM latch with on/off-time guards and bootstrap refresh.
module hs_switch_guard #(
    parameter int MIN_ON   = 8,
    parameter int MIN_OFF  = 18,
    parameter int MAX_ON   = 600,
    parameter int PULL_TMO = 50,
    parameter int IDLE_LIM = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_tick,
    input  logic pwm_end,
    input  logic ocp_trip,
    input  logic light_load,
    input  logic skip_cur_hit,
    input  logic neg_ilim,
    output logic hs_on,
    output logic ls_pull
);

    logic stop_now;
    logic blank_done;
    logic idle_fire;
    logic idle_expired;

    hsg_phase_fsm #(
        .MIN_ON  (MIN_ON),
        .MIN_OFF (MIN_OFF),
        .MAX_ON  (MAX_ON),
        .PULL_TMO(PULL_TMO)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_tick (period_tick),
        .light_load  (light_load),
        .neg_ilim    (neg_ilim),
        .stop_now    (stop_now),
        .idle_expired(idle_expired),
        .hs_on       (hs_on),
        .ls_pull     (ls_pull),
        .blank_done  (blank_done),
        .idle_fire   (idle_fire)
    );

    hsg_off_request u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .on_active   (hs_on),
        .blank_done  (blank_done),
        .pwm_end     (pwm_end),
        .ocp_trip    (ocp_trip),
        .skip_cur_hit(skip_cur_hit),
        .stop_now    (stop_now)
    );

    hsg_idle_timer #(
        .IDLE_LIM(IDLE_LIM)
    ) u_idle (
        .clk         (clk),
        .rst_n       (rst_n),
        .hs_on       (hs_on),
        .idle_fire   (idle_fire),
        .idle_expired(idle_expired)
    );

    // Independent run-length counters on the outputs, for the properties below
    logic [31:0] a_hs_run_q, a_lo_run_q, a_ls_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_hs_run_q <= '0;
            a_lo_run_q <= '0;
            a_ls_run_q <= '0;
        end else begin
            a_hs_run_q <= hs_on   ? a_hs_run_q + 32'd1 : 32'd0;
            a_lo_run_q <= hs_on   ? 32'd0 : a_lo_run_q + 32'd1;
            a_ls_run_q <= ls_pull ? a_ls_run_q + 32'd1 : 32'd0;
        end
    end

    a_r1_min_on: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_on && a_hs_run_q != 32'd0) |-> (a_hs_run_q >= 32'(MIN_ON)));

    a_r3_tick_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> $past(period_tick));

    a_r4_min_off: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on && a_lo_run_q != 32'd0) |-> (a_lo_run_q >= 32'(MIN_OFF)));

    a_r5_max_on: assert property (@(posedge clk) disable iff (!rst_n)
        hs_on |-> (a_hs_run_q < 32'(MAX_ON)));

    a_r5_pull_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on && a_hs_run_q == 32'(MAX_ON - 1)) |=> (!hs_on && !ls_pull) ##1 ls_pull);

    a_r6_pull_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ls_pull |-> (a_ls_run_q < 32'(PULL_TMO)));

    a_r6_neg_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_pull && neg_ilim) |=> !ls_pull);

    a_r7_light_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_on && light_load) |=> !hs_on);

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_pull));

    a_r8_gap_before_pull: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_pull) |-> !$past(hs_on));

    a_r8_gap_before_on: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> !$past(ls_pull));

endmodule

// File: tb/hs_switch_guard_test.sv
module hs_switch_guard_test;

    localparam int CLK_PERIOD = 10;
    localparam int MIN_ON     = 4;
    localparam int MIN_OFF    = 6;
    localparam int MAX_ON     = 40;
    localparam int PULL_TMO   = 8;
    localparam int IDLE_LIM   = 200;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic period_tick = 1'b0;
    logic pwm_end = 1'b0;
    logic ocp_trip = 1'b0;
    logic light_load = 1'b0;
    logic skip_cur_hit = 1'b0;
    logic neg_ilim = 1'b0;
    logic hs_on, ls_pull;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hs_switch_guard #(
        .MIN_ON(MIN_ON), .MIN_OFF(MIN_OFF), .MAX_ON(MAX_ON),
        .PULL_TMO(PULL_TMO), .IDLE_LIM(IDLE_LIM)
    ) uut (
        .clk(clk), .rst_n(rst_n), .period_tick(period_tick),
        .pwm_end(pwm_end), .ocp_trip(ocp_trip), .light_load(light_load),
        .skip_cur_hit(skip_cur_hit), .neg_ilim(neg_ilim),
        .hs_on(hs_on), .ls_pull(ls_pull)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected pulse width for a request in high cycle w (src 3 = none)
    function automatic int exp_on(input int w, input int src);
        if (src == 3 || w < 1 || w >= MAX_ON) return MAX_ON;
        if (w < MIN_ON) return MIN_ON;
        return w;
    endfunction

    function automatic int exp_pull(input int j);
        if (j >= 1 && j <= PULL_TMO) return j;
        return PULL_TMO;
    endfunction

    task automatic drive_req(input int src, input logic v);
        case (src)
            0: pwm_end = v;
            1: ocp_trip = v;
            2: skip_cur_hit = v;
            default: ;
        endcase
    endtask

    // One tick-started pulse; request src in high cycle w; neg_ilim in pull cycle j
    task automatic run_pulse(input int w, input int src, input int j,
                             output int on_len, output int gap, output int ls_len);
        repeat (MIN_OFF + 3) @(negedge clk);
        period_tick = 1'b1;
        @(negedge clk);
        period_tick = 1'b0;
        on_len = 0;
        while (hs_on && on_len < 5000) begin
            on_len++;
            if (on_len == w) drive_req(src, 1'b1);
            @(negedge clk);
            drive_req(src, 1'b0);
        end
        gap = 0;
        ls_len = 0;
        if (on_len >= MAX_ON) begin
            while (!ls_pull && gap < 50) begin
                gap++;
                @(negedge clk);
            end
            while (ls_pull && ls_len < 5000) begin
                ls_len++;
                if (ls_len == j) neg_ilim = 1'b1;
                @(negedge clk);
                neg_ilim = 1'b0;
            end
        end
    endtask

    initial begin
        int on_len, gap, ls_len, lo, hi_seen;
        void'($urandom(32'd20240611));

        // R10: reset state
        repeat (5) @(negedge clk);
        chk("R10 hs_on in reset", int'(hs_on), 0);
        chk("R10 ls_pull in reset", int'(ls_pull), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 hs_on after reset", int'(hs_on), 0);
        chk("R10 ls_pull after reset", int'(ls_pull), 0);

        // R2: plain PWM end at cycle 10
        run_pulse(10, 0, 0, on_len, gap, ls_len);
        chk("R2 pwm_end width", on_len, 10);
        // R1: overcurrent inside blanking is stretched
        run_pulse(1, 1, 0, on_len, gap, ls_len);
        chk("R1 early ocp width", on_len, MIN_ON);
        // R1: skip current inside blanking
        run_pulse(2, 2, 0, on_len, gap, ls_len);
        chk("R1 early skip width", on_len, MIN_ON);
        // R2: overcurrent after blanking and at the boundary
        run_pulse(17, 1, 0, on_len, gap, ls_len);
        chk("R2 late ocp width", on_len, 17);
        run_pulse(MIN_ON, 2, 0, on_len, gap, ls_len);
        chk("R2 skip at MIN_ON", on_len, MIN_ON);

        // R5 + R6: on-time cap, dead cycle, full pull-down
        run_pulse(0, 3, 0, on_len, gap, ls_len);
        chk("R5 capped width", on_len, MAX_ON);
        chk("R8 dead cycle after cap", gap, 1);
        chk("R6 pull timeout length", ls_len, PULL_TMO);
        // R5: request in the cap cycle still caps; R6 early negative limit
        run_pulse(MAX_ON, 0, 3, on_len, gap, ls_len);
        chk("R5 request in cap cycle", on_len, MAX_ON);
        chk("R5 pull follows cap", int'(ls_len > 0), 1);
        chk("R6 neg_ilim stop length", ls_len, 3);

        // R4: tick held from the falling edge gives exactly MIN_OFF low cycles
        run_pulse(5, 0, 0, on_len, gap, ls_len);
        period_tick = 1'b1;
        lo = 0;
        while (!hs_on && lo < 100) begin
            lo++;
            @(negedge clk);
        end
        chk("R4 exact min off", lo, MIN_OFF);
        // R3: held tick during conduction does not restart anything
        pwm_end = 1'b1;
        period_tick = 1'b1;
        on_len = 0;
        while (hs_on && on_len < 100) begin
            on_len++;
            @(negedge clk);
        end
        pwm_end = 1'b0;
        period_tick = 1'b0;
        chk("R1 width with tick held", on_len, MIN_ON);

        // R7: ticks under light load are ignored
        repeat (MIN_OFF + 3) @(negedge clk);
        light_load = 1'b1;
        hi_seen = 0;
        for (int t = 0; t < 3; t++) begin
            period_tick = 1'b1;
            @(negedge clk);
            period_tick = 1'b0;
            for (int c = 0; c < 6; c++) begin
                if (hs_on) hi_seen++;
                @(negedge clk);
            end
        end
        light_load = 1'b0;
        chk("R7 no turn-on under light load", hi_seen, 0);

        // R9: idle refresh timing
        run_pulse(5, 0, 0, on_len, gap, ls_len);
        lo = 0;
        while (!ls_pull && !hs_on && lo < IDLE_LIM + 50) begin
            lo++;
            @(negedge clk);
        end
        chk("R9 idle delay from hs fall", lo, IDLE_LIM);
        ls_len = 0;
        while (ls_pull && ls_len < 100) begin
            ls_len++;
            @(negedge clk);
        end
        chk("R9 idle pull length", ls_len, PULL_TMO);
        lo = 0;
        while (!ls_pull && !hs_on && lo < IDLE_LIM + 50) begin
            lo++;
            @(negedge clk);
        end
        chk("R9 idle repeat spacing", lo + PULL_TMO, IDLE_LIM);
        ls_len = 0;
        while (ls_pull && ls_len < 100) begin
            ls_len++;
            if (ls_len == 2) neg_ilim = 1'b1;
            @(negedge clk);
            neg_ilim = 1'b0;
        end
        chk("R6 idle pull neg_ilim stop", ls_len, 2);

        // Seeded random pulses
        for (int it = 0; it < 40; it++) begin
            int w, src, j;
            w   = int'($urandom_range(1, MAX_ON + 5));
            src = int'($urandom_range(0, 3));
            j   = int'($urandom_range(0, PULL_TMO + 2));
            if ($urandom_range(0, 4) == 0) begin
                repeat (MIN_OFF + 3) @(negedge clk);
                light_load = 1'b1;
                period_tick = 1'b1;
                @(negedge clk);
                period_tick = 1'b0;
                hi_seen = 0;
                for (int c = 0; c < 5; c++) begin
                    if (hs_on) hi_seen++;
                    @(negedge clk);
                end
                light_load = 1'b0;
                chk("R7 random light-load tick", hi_seen, 0);
            end else begin
                run_pulse(w, src, j, on_len, gap, ls_len);
                chk("R2 random pulse width", on_len, exp_on(w, src));
                if (exp_on(w, src) == MAX_ON) begin
                    chk("R8 random dead cycle", gap, 1);
                    chk("R6 random pull length", ls_len, exp_pull(j));
                end
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule